// File: doc/BRIEF.md
# Leaf Entry Rights Check and Reference/Change Updater

This block sits after a page-table walker. The walker hands it a leaf translation entry, the memory address that entry was read from, the faulting effective address, the kind of access (load, store or instruction fetch), the user/supervisor state of the access, and a three-bit rights vector taken from the authority mask. The block works out which rights the entry grants and decides whether the access is allowed. It then builds the entry as it must look once the access has happened.

If the access is refused, the block reports a fault with cause bits. It latches the effective address when the fault is on the data side and writes nothing to memory. If the access is allowed, the block sets the referenced flag, and also the modified flag when the access is a store. If that changes the entry, the block offers a 64-bit write of the new entry to its address over a valid/ready handshake. Each request ends with a one-cycle completion pulse that carries the rights to install in the translation cache.

A request is a single-cycle strobe. It is taken only while the block is idle. While a request is in progress, further strobes are dropped.

Top module: `pte_rights_update`

## Requirements
- R1: When the two-bit attribute field at entry bits [5:4] equals 2'b10 (non-idempotent I/O) and the access kind is fetch (req_kind 2), the request completes as a fault. fault_cause bit 0 (guarded) is set, the rights are zero, and there is no write-back. For loads and stores this attribute value has no effect.
- R2: When the entry's privileged bit (bit 3) is set and req_problem is 1, the granted rights are zero.
- R3: When req_problem is 1, or the privileged bit is set, the granted rights equal entry bits [2:0] and req_mask_rights is ignored. Rights vectors use bit 2 for read, bit 1 for write and bit 0 for execute.
- R4: When req_problem is 0 and the privileged bit is clear, the granted rights are entry bits [2:0] ANDed with req_mask_rights.
- R5: The access kind selects the right it needs: load (0) needs read, store (1) needs write, fetch (2) needs execute. If the granted rights lack that right, the request completes as a fault with fault_cause bit 1 (protection) set, rights zero, and no write-back.
- R6: For an allowed access, the updated entry is the original entry with bit 8 (referenced) set, and with bit 7 (modified) also set for a store. All other bits are unchanged.
- R7: For an allowed load or fetch, done_rights is the granted rights with the write bit cleared. For an allowed store, done_rights is the granted rights unchanged.
- R8: A write-back is offered only when the updated entry differs from the original. wb_addr is the request's entry address and wb_data is the updated entry. wb_valid, wb_addr and wb_data stay stable until wb_ready is seen.
- R9: On a fault from a load or store, fault_cause bit 2 is set for a store only, and fault_addr takes the request's effective address. A fetch fault leaves fault_addr unchanged.
- R10: done pulses for exactly one cycle. It comes in the cycle after the cycle in which wb_valid and wb_ready are both high, or in the cycle after the request when there is no write-back. done_fault, done_rights and fault_cause are valid while done is high.
- R11: A req_valid strobe while busy is high is ignored. It causes no second completion and does not change the write-back contents or fault_addr.
- R12: After reset, busy, wb_valid, done, done_fault, done_rights, fault_cause and fault_addr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe, taken when not busy |
| req_pte | input | PTE_W | Leaf entry to check and update |
| req_pte_addr | input | PA_W | Memory address of the leaf entry |
| req_eaddr | input | EA_W | Effective address of the access |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_problem | input | 1 | 1 for a user-state access |
| req_mask_rights | input | 3 | Rights allowed by the authority mask {R,W,X} |
| wb_ready | input | 1 | Memory accepts the write-back |
| busy | output | 1 | A request is in progress |
| wb_valid | output | 1 | Write-back offered |
| wb_addr | output | PA_W | Write-back address |
| wb_data | output | PTE_W | Updated entry to write |
| done | output | 1 | Completion pulse |
| done_fault | output | 1 | The completed request faulted |
| done_rights | output | 3 | Rights to install {R,W,X} |
| fault_cause | output | 3 | {store, protection, guarded} of the last request |
| fault_addr | output | EA_W | Effective address of the last data-side fault |

## Verification
Some rules are checked by assertions on every cycle: the write-back stays steady while it stalls, completion follows an accepted write-back by one cycle, done never lasts two cycles, a faulted completion never carries rights, and every offered write-back has the referenced flag set. The outcome of the rights calculation can only be shown by the bench's scenarios, which compare against an independent model. This covers the privilege and mask combinations, the missing-right faults per access kind, the stripped write right, and the skipped write-back for an entry that is already up to date. The scenarios also show that fault_addr is kept across fetch faults and that a strobe arriving mid-request is dropped.

// File: rtl/pte_upd_pkg.sv
package pte_upd_pkg;

  // Entry field positions (decoded by neighbours, so fixed)
  localparam int REF_BIT  = 8;
  localparam int CHG_BIT  = 7;
  localparam int ATT_LSB  = 4;
  localparam int ATT_W    = 2;
  localparam int PRIV_BIT = 3;
  localparam int EAA_LSB  = 0;
  localparam int RIGHTS_W = 3;

  localparam logic [ATT_W-1:0] ATT_NONIDEM_IO = 2'b10;

  // Rights vector bit positions
  localparam int RT_R = 2;
  localparam int RT_W = 1;
  localparam int RT_X = 0;

  // Fault cause bit positions
  localparam int CAUSE_W  = 3;
  localparam int CS_GUARD = 0;
  localparam int CS_PROT  = 1;
  localparam int CS_STORE = 2;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_DONE = 2'd2
  } upd_st_e;

endpackage

// File: rtl/pte_rights_eval.sv
module pte_rights_eval
  import pte_upd_pkg::*;
#(
  parameter int PTE_W = 64
) (
  input  logic [PTE_W-1:0]    pte,
  input  logic [1:0]          kind,
  input  logic                problem,
  input  logic [RIGHTS_W-1:0] mask_rights,
  output logic [RIGHTS_W-1:0] granted,
  output logic                guard_flt,
  output logic                prot_flt
);

  logic [ATT_W-1:0]    att;
  logic [RIGHTS_W-1:0] eaa;
  logic                priv;
  logic [RIGHTS_W-1:0] need;

  always_comb begin
    att  = pte[ATT_LSB +: ATT_W];
    eaa  = pte[EAA_LSB +: RIGHTS_W];
    priv = pte[PRIV_BIT];

    guard_flt = (att == ATT_NONIDEM_IO) && (kind == ACC_FETCH);

    if (priv && problem) begin
      granted = '0;
    end else if (problem || priv) begin
      granted = eaa;
    end else begin
      granted = eaa & mask_rights;
    end

    need = '0;
    case (kind)
      ACC_STORE: need[RT_W] = 1'b1;
      ACC_FETCH: need[RT_X] = 1'b1;
      default:   need[RT_R] = 1'b1;
    endcase

    prot_flt = !guard_flt && (|(need & ~granted));
  end

endmodule

// File: rtl/pte_rc_merge.sv
module pte_rc_merge
  import pte_upd_pkg::*;
#(
  parameter int PTE_W = 64
) (
  input  logic [PTE_W-1:0]    pte,
  input  logic [1:0]          kind,
  input  logic [RIGHTS_W-1:0] granted,
  output logic [PTE_W-1:0]    new_pte,
  output logic                changed,
  output logic [RIGHTS_W-1:0] ret_rights
);

  logic is_store;

  always_comb begin
    is_store = (kind == ACC_STORE);
    new_pte  = pte;
    new_pte[REF_BIT] = 1'b1;
    if (is_store) begin
      new_pte[CHG_BIT] = 1'b1;
    end
    changed    = (new_pte != pte);
    ret_rights = granted;
    if (!is_store) begin
      ret_rights[RT_W] = 1'b0;
    end
  end

endmodule

// File: rtl/pte_wb_ctrl.sv
module pte_wb_ctrl
  import pte_upd_pkg::*;
#(
  parameter int PTE_W = 64,
  parameter int PA_W  = 56,
  parameter int EA_W  = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                fault_in,
  input  logic [CAUSE_W-1:0]  cause_in,
  input  logic                data_side,
  input  logic                need_wb,
  input  logic [PTE_W-1:0]    new_pte,
  input  logic [PA_W-1:0]     pte_addr,
  input  logic [EA_W-1:0]     eaddr,
  input  logic [RIGHTS_W-1:0] rights_in,
  input  logic                wb_ready,
  output logic                busy,
  output logic                wb_valid,
  output logic [PA_W-1:0]     wb_addr,
  output logic [PTE_W-1:0]    wb_data,
  output logic                done,
  output logic                done_fault,
  output logic [RIGHTS_W-1:0] done_rights,
  output logic [CAUSE_W-1:0]  fault_cause,
  output logic [EA_W-1:0]     fault_addr
);

  upd_st_e             st_q, st_d;
  logic                accept;
  logic                ld_wb, ld_fa;
  logic [PTE_W-1:0]    data_q;
  logic [PA_W-1:0]     addr_q;
  logic [RIGHTS_W-1:0] rights_q, rights_d;
  logic [CAUSE_W-1:0]  cause_q, cause_d;
  logic                flt_q;
  logic [EA_W-1:0]     fa_q;

  always_comb begin
    accept   = req_valid && (st_q == ST_IDLE);
    ld_wb    = accept && !fault_in && need_wb;
    ld_fa    = accept && fault_in && data_side;
    rights_d = fault_in ? '0 : rights_in;
    cause_d  = fault_in ? cause_in : '0;
    st_d     = st_q;
    case (st_q)
      ST_IDLE: if (accept) st_d = (fault_in || !need_wb) ? ST_DONE : ST_WB;
      ST_WB:   if (wb_ready) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      data_q   <= '0;
      addr_q   <= '0;
      rights_q <= '0;
      cause_q  <= '0;
      flt_q    <= 1'b0;
      fa_q     <= '0;
    end else begin
      st_q <= st_d;
      if (ld_wb) begin
        data_q <= new_pte;
        addr_q <= pte_addr;
      end
      if (accept) begin
        rights_q <= rights_d;
        cause_q  <= cause_d;
        flt_q    <= fault_in;
      end
      if (ld_fa) begin
        fa_q <= eaddr;
      end
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign wb_valid    = (st_q == ST_WB);
  assign wb_addr     = addr_q;
  assign wb_data     = data_q;
  assign done        = (st_q == ST_DONE);
  assign done_fault  = flt_q;
  assign done_rights = rights_q;
  assign fault_cause = cause_q;
  assign fault_addr  = fa_q;

  // R8
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_data) && $stable(wb_addr)));

  // R10
  done_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready) |=> done);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  busy_fa_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(fault_addr));

  // R5
  fault_no_rights_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fault) |-> (done_rights == '0));

endmodule

// File: rtl/pte_rights_update.sv
module pte_rights_update
  import pte_upd_pkg::*;
#(
  parameter int PTE_W = 64,
  parameter int PA_W  = 56,
  parameter int EA_W  = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [PTE_W-1:0]    req_pte,
  input  logic [PA_W-1:0]     req_pte_addr,
  input  logic [EA_W-1:0]     req_eaddr,
  input  logic [1:0]          req_kind,
  input  logic                req_problem,
  input  logic [2:0]          req_mask_rights,
  input  logic                wb_ready,
  output logic                busy,
  output logic                wb_valid,
  output logic [PA_W-1:0]     wb_addr,
  output logic [PTE_W-1:0]    wb_data,
  output logic                done,
  output logic                done_fault,
  output logic [2:0]          done_rights,
  output logic [2:0]          fault_cause,
  output logic [EA_W-1:0]     fault_addr
);

  logic [RIGHTS_W-1:0] granted, ret_rights;
  logic                guard_flt, prot_flt, fault_any, data_side, changed;
  logic [PTE_W-1:0]    new_pte;
  logic [CAUSE_W-1:0]  cause;

  pte_rights_eval #(.PTE_W(PTE_W)) u_eval (
    .pte         (req_pte),
    .kind        (req_kind),
    .problem     (req_problem),
    .mask_rights (req_mask_rights),
    .granted     (granted),
    .guard_flt   (guard_flt),
    .prot_flt    (prot_flt)
  );

  pte_rc_merge #(.PTE_W(PTE_W)) u_merge (
    .pte        (req_pte),
    .kind       (req_kind),
    .granted    (granted),
    .new_pte    (new_pte),
    .changed    (changed),
    .ret_rights (ret_rights)
  );

  always_comb begin
    fault_any       = guard_flt || prot_flt;
    data_side       = (req_kind != ACC_FETCH);
    cause           = '0;
    cause[CS_GUARD] = guard_flt;
    cause[CS_PROT]  = prot_flt;
    cause[CS_STORE] = fault_any && (req_kind == ACC_STORE);
  end

  pte_wb_ctrl #(.PTE_W(PTE_W), .PA_W(PA_W), .EA_W(EA_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .fault_in    (fault_any),
    .cause_in    (cause),
    .data_side   (data_side),
    .need_wb     (changed),
    .new_pte     (new_pte),
    .pte_addr    (req_pte_addr),
    .eaddr       (req_eaddr),
    .rights_in   (ret_rights),
    .wb_ready    (wb_ready),
    .busy        (busy),
    .wb_valid    (wb_valid),
    .wb_addr     (wb_addr),
    .wb_data     (wb_data),
    .done        (done),
    .done_fault  (done_fault),
    .done_rights (done_rights),
    .fault_cause (fault_cause),
    .fault_addr  (fault_addr)
  );

  // R6
  wb_ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_data[REF_BIT]);

  // R1
  guard_not_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_cause[CS_GUARD]) |-> (done_fault && !fault_cause[CS_STORE]));

  // R10
  no_wb_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wb_valid);

endmodule

// File: tb/pte_rights_update_tb.sv
`timescale 1ns/1ps
module pte_rights_update_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [63:0] req_pte;
  logic [55:0] req_pte_addr;
  logic [63:0] req_eaddr;
  logic [1:0]  req_kind;
  logic        req_problem;
  logic [2:0]  req_mask_rights;
  logic        wb_ready;
  logic        busy, wb_valid, done, done_fault;
  logic [55:0] wb_addr;
  logic [63:0] wb_data;
  logic [2:0]  done_rights, fault_cause;
  logic [63:0] fault_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [63:0] fa_exp = '0;

  always #2.5 clk = ~clk;

  pte_rights_update u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pte(req_pte),
    .req_pte_addr(req_pte_addr), .req_eaddr(req_eaddr), .req_kind(req_kind),
    .req_problem(req_problem), .req_mask_rights(req_mask_rights),
    .wb_ready(wb_ready), .busy(busy), .wb_valid(wb_valid), .wb_addr(wb_addr),
    .wb_data(wb_data), .done(done), .done_fault(done_fault),
    .done_rights(done_rights), .fault_cause(fault_cause), .fault_addr(fault_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Independent model of the requirements
  function automatic void model(input logic [63:0] pte, input logic [1:0] kind,
                                input logic prob, input logic [2:0] mask,
                                output bit flt, output logic [2:0] cause,
                                output logic [2:0] rights, output logic [63:0] npte,
                                output bit wb);
    logic [2:0] g, need;
    bit guard;
    guard = (pte[5:4] == 2'b10) && (kind == 2'd2);               // R1
    if (pte[3] && prob) g = 3'b000;                               // R2
    else if (prob || pte[3]) g = pte[2:0];                        // R3
    else g = pte[2:0] & mask;                                     // R4
    need = (kind == 2'd1) ? 3'b010 : (kind == 2'd2) ? 3'b001 : 3'b100; // R5
    flt = guard || ((need & ~g) != 0);
    cause = {flt && kind == 2'd1, !guard && flt, guard};
    rights = flt ? 3'b000 : ((kind == 2'd1) ? g : (g & 3'b101)); // R7
    npte = pte | 64'h100 | ((kind == 2'd1) ? 64'h80 : 64'h0);      // R6
    wb = !flt && (npte != pte);                                   // R8
  endfunction

  task automatic run_req(input logic [63:0] pte, input logic [55:0] pa,
                         input logic [63:0] ea, input logic [1:0] kind,
                         input logic prob, input logic [2:0] mask,
                         input int stall, input bit intrude);
    bit flt, wb;
    logic [2:0] cause, rights;
    logic [63:0] npte;
    model(pte, kind, prob, mask, flt, cause, rights, npte, wb);
    @(negedge clk);
    req_valid = 1'b1; req_pte = pte; req_pte_addr = pa; req_eaddr = ea;
    req_kind = kind; req_problem = prob; req_mask_rights = mask;
    @(negedge clk);
    req_valid = 1'b0;
    if (wb) begin
      chk(wb_valid === 1'b1, "R8 wb offered", {63'd0, wb_valid}, 64'd1);
      chk(wb_data === npte, "R6 updated entry", wb_data, npte);
      chk(wb_addr === pa, "R8 wb address", {8'd0, wb_addr}, {8'd0, pa});
      chk(done === 1'b0, "R10 no done before accept", {63'd0, done}, 64'd0);
      for (int i = 0; i < stall; i++) begin
        if (intrude && i == 0) begin
          req_valid = 1'b1; req_pte = ~pte; req_pte_addr = ~pa;
          req_eaddr = ~ea; req_kind = 2'd1; req_problem = 1'b1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(wb_valid === 1'b1 && wb_data === npte, "R8 wb held while stalled",
            wb_data, npte);
        if (intrude)
          chk(wb_addr === pa, "R11 strobe while busy ignored",
              {8'd0, wb_addr}, {8'd0, pa});
      end
      wb_ready = 1'b1;
      @(negedge clk);
      wb_ready = 1'b0;
    end else begin
      chk(wb_valid === 1'b0, "R8 no write-back", {63'd0, wb_valid}, 64'd0);
      if (flt && kind != 2'd2) fa_exp = ea;                        // R9
    end
    chk(done === 1'b1, "R10 done pulse", {63'd0, done}, 64'd1);
    chk(done_fault === flt, "R5 fault flag", {63'd0, done_fault}, {63'd0, flt});
    chk(done_rights === rights, "R7 returned rights", {61'd0, done_rights},
        {61'd0, rights});
    chk(fault_cause === cause, "R9 fault cause", {61'd0, fault_cause},
        {61'd0, cause});
    chk(fault_addr === fa_exp, "R9 fault address", fault_addr, fa_exp);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R11 single completion, idle",
        {62'd0, done, busy}, 64'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_valid = 1'b0; req_pte = '0; req_pte_addr = '0;
    req_eaddr = '0; req_kind = '0; req_problem = 1'b0; req_mask_rights = '0;
    wb_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk({busy, wb_valid, done, done_fault} === 4'b0, "R12 reset controls",
        {60'd0, busy, wb_valid, done, done_fault}, 64'd0);
    chk(done_rights === 3'b0 && fault_cause === 3'b0, "R12 reset rights/cause",
        {58'd0, done_rights, fault_cause}, 64'd0);
    chk(fault_addr === 64'd0, "R12 reset fault_addr", fault_addr, 64'd0);

    // R1 guarded fetch, then same attribute on load
    run_req(64'h0000_0000_0000_0027, 56'h1000, 64'hA0, 2'd2, 1'b0, 3'b111, 0, 0);
    run_req(64'h0000_0000_0000_0027, 56'h1008, 64'hA8, 2'd0, 1'b0, 3'b111, 1, 0);
    // R2 privileged entry in problem state
    run_req(64'h0000_0000_0000_000F, 56'h2000, 64'hB0, 2'd0, 1'b1, 3'b111, 0, 0);
    // R3 problem state ignores mask
    run_req(64'h0000_0000_0000_0006, 56'h2008, 64'hB8, 2'd1, 1'b1, 3'b000, 2, 0);
    // R4 supervisor, non-privileged: mask removes write
    run_req(64'h0000_0000_0000_0007, 56'h2010, 64'hC0, 2'd1, 1'b0, 3'b101, 0, 0);
    // R5 fetch without execute right (fetch fault keeps fault_addr, R9)
    run_req(64'h0000_0000_0000_0006, 56'h2018, 64'hC8, 2'd2, 1'b0, 3'b111, 0, 0);
    // R6/R8 store with both flags already set: no write-back
    run_req(64'h0000_0000_0000_0182, 56'h2020, 64'hD0, 2'd1, 1'b0, 3'b111, 0, 0);
    // R7 load with reference already set: no write-back, write stripped
    run_req(64'h0000_0000_0000_0107, 56'h2028, 64'hD8, 2'd0, 1'b0, 3'b111, 0, 0);
    // R11 strobe during a stalled write-back
    run_req(64'h1234_0000_0000_0004, 56'h3000, 64'hE0, 2'd0, 1'b0, 3'b111, 3, 1);

    for (int n = 0; n < 400; n++) begin
      logic [63:0] p;
      logic [1:0]  k;
      p = {$urandom, $urandom};
      k = 2'($urandom_range(0, 2));
      run_req(p, {$urandom, 24'($urandom)}, {$urandom, $urandom}, k,
              1'($urandom), 3'($urandom), $urandom_range(0, 2), 1'($urandom));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule